// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command-register state machine of a 16-bit parallel nonvolatile memory. It watches synchronous bus write cycles. Each write carries an address and a data word. The block recognises keyed multi-cycle sequences: two unlock writes, a command write, and for some commands further writes. These sequences move the device between array read, identification read, secured-region access, word program and chip erase.

Reads are served with one cycle of latency. In identification mode a read returns the identification word for its offset. In every other mode the read is forwarded to the array, and the array's word is returned. Program and erase are issued as one-cycle request pulses to the array's write engine, which lies outside this block. While that engine reports busy, sequence writes are ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A sequence starts with data AAh written to address 555h, followed by 55h written to 2AAh; the command word is then written to 555h. Only address bits [10:0] and data bits [7:0] are compared on these writes.
- R2: Command 90h selects identification mode (`mode` = 1). Reads do not change the mode.
- R3: In identification mode, a read at offset `rd_addr[7:0]` returns one word. Offset 00h gives 00C2h and offset 01h gives 22FDh. Offset 03h gives 0088h when `factory_locked` is 1, and 0048h otherwise. Any other offset gives 0000h. `rd_valid` and `rd_data` appear the cycle after `rd_en`.
- R4: In read mode (`mode` = 0) and secured mode, a read raises `arr_rd_en` with `arr_raddr` = `rd_addr`. The word returned is `arr_rdata` as sampled in that cycle.
- R5: Command 88h selects secured-region mode (`mode` = 2).
- R6: After command A0h, the next write produces a one-cycle `prog_req` in the following cycle. That pulse carries the write's full address and data, and the mode is then 0.
- R7: Command 80h followed by AAh@555h, 55h@2AAh and 10h@555h produces a one-cycle `erase_req`, and the mode is then 0.
- R8: A write that does not match the expected address and data of its step sets the mode to 0 and restarts the sequence.
- R9: A write with data bits [7:0] = F0h at any address sets the mode to 0. This applies at every step except the program-data write, where F0h is programmed as data.
- R10: In secured mode, the unlock pair followed by 90h@555h keeps the secured mode. A following write of 00h to any address returns the mode to 0.
- R11: A write presented while `busy` is 1 has no effect on the mode, the sequence or the request outputs.
- R12: After reset the mode is 0 and `prog_req`, `erase_req` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 21 | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Array write engine busy |
| factory_locked | input | 1 | Selects the lock code returned at ID offset 03h |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 21 | Read address |
| arr_rd_en | output | 1 | Read forwarded to the array |
| arr_raddr | output | 21 | Array read address |
| arr_rdata | input | 16 | Array read data, same cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| mode | output | 2 | 0 read, 1 identification, 2 secured |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 21 | Program address |
| prog_data | output | 16 | Program data |
| erase_req | output | 1 | One-cycle chip-erase request |

## Verification
The assertions check several rules on every cycle. A reset code or a first write that is not the unlock key always returns the mode to read. Busy writes leave the mode frozen. Program and erase pulses last one cycle and never overlap. Each read yields a valid word the next cycle. The bench scenarios cover what needs whole sequences: the identification words per offset and lock status, and program and erase pulses that carry the right address and data. They also cover aborts deep inside the erase sequence, a program write whose data is F0h, the secured-region exit, and the masking of upper address and data bits.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {
    M_READ = 2'd0,
    M_ID   = 2'd1,
    M_SEC  = 2'd2
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_U1   = 3'd1,
    S_U2   = 3'd2,
    S_PROG = 3'd3,
    S_E3   = 3'd4,
    S_E4   = 3'd5,
    S_E5   = 3'd6,
    S_EXIT = 3'd7
  } step_t;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_SEC   = 8'h88;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_RST   = 8'hF0;
  localparam logic [7:0] CMD_LEAVE = 8'h00;
endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int AW  = 21,
  parameter int DW  = 16,
  parameter int CAW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output mode_t         mode,
  output step_t         step,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          erase_req
);
  localparam logic [CAW-1:0] ADDR_HI = CAW'(12'h555);
  localparam logic [CAW-1:0] ADDR_LO = CAW'(12'h2AA);

  logic       at_hi, at_lo, take;
  logic [7:0] code;

  assign at_hi = (wr_addr[CAW-1:0] == ADDR_HI);
  assign at_lo = (wr_addr[CAW-1:0] == ADDR_LO);
  assign code  = wr_data[7:0];
  assign take  = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_READ;
      step      <= S_IDLE;
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      if (take) begin
        if (step != S_PROG && code == CMD_RST) begin
          mode <= M_READ;
          step <= S_IDLE;
        end else begin
          // default outcome of a write: abort to array read
          mode <= M_READ;
          step <= S_IDLE;
          case (step)
            S_IDLE: if (at_hi && code == KEY_A) begin
              mode <= mode;
              step <= S_U1;
            end
            S_U1: if (at_lo && code == KEY_B) begin
              mode <= mode;
              step <= S_U2;
            end
            S_U2: if (at_hi) begin
              case (code)
                CMD_ID: begin
                  if (mode == M_SEC) begin
                    mode <= M_SEC;
                    step <= S_EXIT;
                  end else begin
                    mode <= M_ID;
                  end
                end
                CMD_SEC:   mode <= M_SEC;
                CMD_PROG:  begin mode <= mode; step <= S_PROG; end
                CMD_ERASE: begin mode <= mode; step <= S_E3; end
                default: ;
              endcase
            end
            S_PROG: begin
              prog_req  <= 1'b1;
              prog_addr <= wr_addr;
              prog_data <= wr_data;
            end
            S_E3: if (at_hi && code == KEY_A) begin
              mode <= mode;
              step <= S_E4;
            end
            S_E4: if (at_lo && code == KEY_B) begin
              mode <= mode;
              step <= S_E5;
            end
            S_E5: if (at_hi && code == CMD_CHIP) erase_req <= 1'b1;
            S_EXIT: ;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fcd_id_table.sv
module fcd_id_table #(
  parameter int          DW          = 16,
  parameter logic [15:0] MFR_WORD    = 16'h00C2,
  parameter logic [15:0] DEV_WORD    = 16'h22FD,
  parameter logic [15:0] LOCKED_WORD = 16'h0088,
  parameter logic [15:0] OPEN_WORD   = 16'h0048
) (
  input  logic [7:0]    offset,
  input  logic          locked,
  output logic [DW-1:0] word
);
  always_comb begin
    case (offset)
      8'h00:   word = DW'(MFR_WORD);
      8'h01:   word = DW'(DEV_WORD);
      8'h03:   word = locked ? DW'(LOCKED_WORD) : DW'(OPEN_WORD);
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/fcd_read_port.sv
module fcd_read_port
  import fcd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  mode_t         mode,
  input  logic [DW-1:0] id_word,
  input  logic [DW-1:0] arr_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= (mode == M_ID) ? id_word : arr_rdata;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW  = 21,
  parameter int DW  = 16,
  parameter int CAW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  input  logic          factory_locked,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          arr_rd_en,
  output logic [AW-1:0] arr_raddr,
  input  logic [DW-1:0] arr_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    mode,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          erase_req
);
  mode_t         cur_mode;
  step_t         seq_step;
  logic [DW-1:0] id_word;

  fcd_seq_fsm #(.AW(AW), .DW(DW), .CAW(CAW)) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .mode(cur_mode), .step(seq_step), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req)
  );

  fcd_id_table #(.DW(DW)) u_id (
    .offset(rd_addr[7:0]), .locked(factory_locked), .word(id_word)
  );

  fcd_read_port #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .mode(cur_mode), .id_word(id_word),
    .arr_rdata(arr_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign mode      = cur_mode;
  assign arr_rd_en = rd_en && (cur_mode != M_ID);
  assign arr_raddr = rd_addr;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
  import fcd_pkg::*;
#(
  parameter int CAW = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [CAW-1:0] wr_addr_lo,
  input logic [7:0]     wr_code,
  input logic           busy,
  input logic           rd_en,
  input logic [1:0]     mode,
  input logic [2:0]     step,
  input logic           prog_req,
  input logic           erase_req,
  input logic           rd_valid
);
  p_bad_first_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && step == S_IDLE &&
     !(wr_addr_lo == CAW'(12'h555) && wr_code == KEY_A)) |=> (mode == M_READ));

  p_reset_code_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_code == CMD_RST && step != S_PROG)
      |=> (mode == M_READ && step == S_IDLE));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> ($stable(mode) && $stable(step) && !prog_req && !erase_req));

  p_prog_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);

  p_prog_mode_r6: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> (mode == M_READ));

  p_erase_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> !erase_req);

  p_req_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, erase_req}));

  p_rd_lat_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_rd_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.CAW(CAW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr_lo(wr_addr[CAW-1:0]),
  .wr_code(wr_data[7:0]), .busy(busy), .rd_en(rd_en), .mode(mode),
  .step(seq_step), .prog_req(prog_req), .erase_req(erase_req), .rd_valid(rd_valid)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          factory_locked = 1'b1;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          arr_rd_en;
  logic [AW-1:0] arr_raddr;
  logic [DW-1:0] arr_rdata;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [1:0]    mode;
  logic          prog_req;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          erase_req;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int            kind;   // 0 read, 1 program, 2 erase
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // array stub: word derived from the address
  assign arr_rdata = arr_raddr[15:0] ^ 16'h5A5A;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .factory_locked(factory_locked), .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_rd_en(arr_rd_en), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mode(mode), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    exp_t e;
    e.kind = 0; e.addr = a; e.data = exp; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1;
    check(arr_rd_en == (mode != 2'd1), "R4", "arr_rd_en", 32'(arr_rd_en), 32'(mode != 2'd1));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_req(input int kind, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string req);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.req = req;
    sb.push_back(e);
  endtask

  task automatic unlock(input logic [7:0] cmd);
    wr(21'h000555, 16'h00AA);
    wr(21'h0002AA, 16'h0055);
    wr(21'h000555, {8'h00, cmd});
  endtask

  task automatic check_mode(input logic [1:0] exp, input string req);
    check(mode == exp, req, "mode", 32'(mode), 32'(exp));
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (!rst && (rd_valid || prog_req || erase_req)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "unexpected output event",
              {29'd0, rd_valid, prog_req, erase_req}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.kind == 0) begin
          check(rd_valid && rd_data == e.data, e.req, "read data", 32'(rd_data), 32'(e.data));
        end else if (e.kind == 1) begin
          check(prog_req && !erase_req, e.req, "program pulse",
                {30'd0, prog_req, erase_req}, 32'd2);
          check(prog_addr == e.addr && prog_data == e.data, e.req, "program addr/data",
                {prog_addr[15:0], prog_data}, {e.addr[15:0], e.data});
        end else begin
          check(erase_req && !prog_req, e.req, "erase pulse",
                {30'd0, prog_req, erase_req}, 32'd1);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check_mode(2'd0, "R12");
    check(!prog_req && !erase_req && !rd_valid, "R12", "pulses after reset",
          {29'd0, prog_req, erase_req, rd_valid}, 32'd0);

    // R4 array read in read mode
    rd(21'h00123, 16'h0123 ^ 16'h5A5A, "R4");

    // R1 upper bits ignored, R2 identification mode
    wr(21'h1F0555, 16'h12AA);
    wr(21'h0A32AA, 16'h0055);
    wr(21'h100555, 16'h0090);
    check_mode(2'd1, "R2");
    rd(21'h000000, 16'h00C2, "R3");
    rd(21'h000001, 16'h22FD, "R3");
    rd(21'h000003, 16'h0088, "R3");
    rd(21'h000002, 16'h0000, "R3");
    factory_locked = 1'b0;
    rd(21'h000003, 16'h0048, "R3");
    factory_locked = 1'b1;
    check_mode(2'd1, "R2");

    // R9 reset code leaves identification mode
    wr(21'h000777, 16'h00F0);
    check_mode(2'd0, "R9");
    rd(21'h00040, 16'h0040 ^ 16'h5A5A, "R4");

    // R6 word program
    unlock(8'hA0);
    expect_req(1, 21'h1ABCD, 16'h1234, "R6");
    wr(21'h1ABCD, 16'h1234);
    check_mode(2'd0, "R6");

    // R9 exception: F0 as program data
    unlock(8'hA0);
    expect_req(1, 21'h00055, 16'h00F0, "R9");
    wr(21'h00055, 16'h00F0);

    // R7 chip erase
    unlock(8'h80);
    wr(21'h000555, 16'h00AA);
    wr(21'h0002AA, 16'h0055);
    expect_req(2, '0, '0, "R7");
    wr(21'h000555, 16'h0010);
    check_mode(2'd0, "R7");

    // R8 wrong address in unlock restarts the sequence
    wr(21'h000555, 16'h00AA);
    wr(21'h0002AB, 16'h0055);
    wr(21'h0002AA, 16'h0055);
    wr(21'h000555, 16'h0090);
    check_mode(2'd0, "R8");
    // R8 stray write leaves identification mode
    unlock(8'h90);
    check_mode(2'd1, "R2");
    wr(21'h000100, 16'h0012);
    check_mode(2'd0, "R8");
    // R8 abort at the last erase step: no pulse (monitor flags any)
    unlock(8'h80);
    wr(21'h000555, 16'h00AA);
    wr(21'h0002AA, 16'h0055);
    wr(21'h000555, 16'h0020);
    check_mode(2'd0, "R8");

    // R5 secured region, R10 exit
    unlock(8'h88);
    check_mode(2'd2, "R5");
    rd(21'h00077, 16'h0077 ^ 16'h5A5A, "R4");
    unlock(8'h90);
    check_mode(2'd2, "R10");
    wr(21'h000003, 16'h0000);
    check_mode(2'd0, "R10");

    // R11 busy writes ignored
    busy = 1'b1;
    unlock(8'h90);
    check_mode(2'd0, "R11");
    wr(21'h000555, 16'h00AA);
    busy = 1'b0;
    wr(21'h0002AA, 16'h0055);
    wr(21'h000555, 16'h0090);
    check_mode(2'd0, "R11");
    unlock(8'h88);
    busy = 1'b1;
    wr(21'h000100, 16'h0012);
    busy = 1'b0;
    check_mode(2'd2, "R11");
    wr(21'h000000, 16'h00F0);

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R6", "scoreboard drained", 32'(sb.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule